// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This unit sits after a floating-point operation and folds the five IEEE exception flags that the operation raised into a status register. It checks the raised flags against the trap-enable mask held in the register. If no raised flag is enabled, the instruction completes: the flags become the current-exception field, they are ORed into the accrued field, and the program counter pair moves forward. If any raised flag is enabled, a trap is taken instead. The current-exception field then holds only the single most severe enabled flag. The accrued field is left alone, the trap-type field is set to the IEEE-exception code, and the program counter pair is held so the faulting instruction can be delivered.

A load port places a status word and a PC/NPC pair into the unit before operations run. This is how the trap-enable mask and the starting program counter are set. Delivering the trap is handled elsewhere. The unit only reports the trap, for one cycle, on `trap_o`.

Top module: `fp_exc_recorder`

## Requirements
- R1: After the asynchronous active-low reset, `stat_o` is zero, `pc_o` is `RESET_PC`, `npc_o` is `RESET_PC`+4, and `trap_o` is low.
- R2: When `cfg_load` is high at a clock edge, `stat_o`, `pc_o` and `npc_o` take `cfg_stat`, `cfg_pc` and `cfg_npc`. This wins over a strobe in the same cycle, and `trap_o` is then low.
- R3: In the cycle after an `op_valid` strobe, `trap_o` is high exactly when `op_flags` and the enable mask in status bits 27:23 share a set bit. Flag bits are invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0.
- R4: After a strobe with no trap, status bits 4:0 equal `op_flags`, and status bits 9:5 become their old value ORed with `op_flags`.
- R5: After a trapping strobe, status bits 4:0 hold only the highest-numbered bit of `op_flags` AND mask (invalid first, inexact last), and bits 9:5 are unchanged.
- R6: After a trapping strobe, status bits 16:14 equal 3'b001. A strobe that does not trap leaves them unchanged.
- R7: After a strobe with no trap, `pc_o` takes the old `npc_o` and `npc_o` becomes the old `npc_o`+4. After a trapping strobe both are held.
- R8: A strobe with `op_flags` all zero clears status bits 4:0, leaves bits 9:5 unchanged, and advances PC and NPC.
- R9: Status bits outside the current, accrued and trap-type fields never change on a strobe. With neither strobe nor load, all outputs hold and `trap_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Loads status word and PC pair |
| cfg_stat | input | SW | Status word to load |
| cfg_pc | input | AW | PC to load |
| cfg_npc | input | AW | NPC to load |
| op_valid | input | 1 | Operation-complete strobe |
| op_flags | input | 5 | Exception flags raised by the operation |
| stat_o | output | SW | Status register |
| pc_o | output | AW | Program counter |
| npc_o | output | AW | Next program counter |
| trap_o | output | 1 | Trap taken by the previous strobe |

## Verification
On every cycle, the assertions check the relation between the trap decision and the program counters. They check that the PC pair is held on a trap and advanced otherwise, that the accrued field is frozen on a trap, that a trap leaves exactly one current-exception bit, that the trap-type code is written, and that the outputs hold when the unit is idle. Only the directed scenarios can show the following: which flag survives when several enabled flags collide; that the ORed accrued value matches a history of operations; that untouched status bits survive; and that a load wins over a simultaneous strobe.

// File: rtl/fp_exc_recorder.sv
`timescale 1ns/1ps
module fp_exc_recorder #(
  parameter int SW = 32,
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [SW-1:0] cfg_stat,
  input  logic [AW-1:0] cfg_pc,
  input  logic [AW-1:0] cfg_npc,
  input  logic          op_valid,
  input  logic [4:0]    op_flags,
  output logic [SW-1:0] stat_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] npc_o,
  output logic          trap_o
);
  localparam int NF     = 5;
  localparam int CUR_LO = 0;
  localparam int ACC_LO = 5;
  localparam int TT_LO  = 14;
  localparam int TT_W   = 3;
  localparam int EN_LO  = 23;
  localparam logic [TT_W-1:0] TT_IEEE = TT_W'(1);

  logic [SW-1:0] stat_q, stat_d;
  logic [AW-1:0] pc_q, npc_q;
  logic          trap_q;

  wire [NF-1:0] en_mask = stat_q[EN_LO +: NF];
  wire [NF-1:0] hit     = op_flags & en_mask;
  wire          take    = |hit;

  logic [NF-1:0] pick;
  always_comb begin
    pick = '0;
    for (int i = 0; i < NF; i++)
      if (hit[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
  end

  wire [NF-1:0] cur = take ? pick : op_flags;

  always_comb begin
    stat_d = stat_q;
    stat_d[CUR_LO +: NF] = cur;
    if (take) stat_d[TT_LO +: TT_W] = TT_IEEE;
    else      stat_d[ACC_LO +: NF] = stat_q[ACC_LO +: NF] | op_flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      pc_q   <= RESET_PC;
      npc_q  <= RESET_PC + AW'(4);
      trap_q <= 1'b0;
    end else if (cfg_load) begin
      stat_q <= cfg_stat;
      pc_q   <= cfg_pc;
      npc_q  <= cfg_npc;
      trap_q <= 1'b0;
    end else if (op_valid) begin
      stat_q <= stat_d;
      trap_q <= take;
      if (!take) begin
        pc_q  <= npc_q;
        npc_q <= npc_q + AW'(4);
      end
    end else begin
      trap_q <= 1'b0;
    end
  end

  assign stat_o = stat_q;
  assign pc_o   = pc_q;
  assign npc_o  = npc_q;
  assign trap_o = trap_q;

  p_trap_decision_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !cfg_load) |=> (trap_o == |($past(op_flags) & $past(stat_o[EN_LO +: NF]))));

  p_trap_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $onehot(stat_o[CUR_LO +: NF]));

  p_acc_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $stable(stat_o[ACC_LO +: NF]));

  p_trap_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (stat_o[TT_LO +: TT_W] == TT_IEEE));

  p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> ($stable(pc_o) && $stable(npc_o)));

  p_pc_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !cfg_load && ((op_flags & stat_o[EN_LO +: NF]) == '0))
      |=> (pc_o == $past(npc_o) && npc_o == $past(npc_o) + AW'(4)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !cfg_load) |=> ($stable(stat_o) && $stable(pc_o) && !trap_o));
endmodule

// File: tb/fp_exc_recorder_tb_top.sv
`timescale 1ns/1ps
module fp_exc_recorder_tb_top;
  localparam int SW = 32;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 1'b0, op_valid = 1'b0;
  logic [SW-1:0] cfg_stat = '0;
  logic [AW-1:0] cfg_pc = '0, cfg_npc = '0;
  logic [4:0] op_flags = '0;
  logic [SW-1:0] stat_o;
  logic [AW-1:0] pc_o, npc_o;
  logic trap_o;

  int checks = 0, errors = 0;
  logic [SW-1:0] es;
  logic [AW-1:0] epc, enpc;
  logic et;

  always #2 clk = ~clk;

  fp_exc_recorder #(.SW(SW), .AW(AW), .RESET_PC('0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_stat(cfg_stat),
    .cfg_pc(cfg_pc), .cfg_npc(cfg_npc), .op_valid(op_valid), .op_flags(op_flags),
    .stat_o(stat_o), .pc_o(pc_o), .npc_o(npc_o), .trap_o(trap_o));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " stat"}, 64'(stat_o), 64'(es));
    chk({req, " pc"}, 64'(pc_o), 64'(epc));
    chk({req, " npc"}, 64'(npc_o), 64'(enpc));
    chk({req, " trap"}, 64'(trap_o), 64'(et));
  endtask

  task automatic load(input logic [SW-1:0] s, input logic [AW-1:0] p, input logic [AW-1:0] n,
                      input logic with_op, input logic [4:0] f);
    @(negedge clk);
    cfg_load = 1'b1; cfg_stat = s; cfg_pc = p; cfg_npc = n;
    op_valid = with_op; op_flags = f;
    @(posedge clk); #1;
    cfg_load = 1'b0; op_valid = 1'b0;
    es = s; epc = p; enpc = n; et = 1'b0;
    check_all("R2");
  endtask

  task automatic op(input logic [4:0] f, input string req);
    logic [4:0] hit, pick;
    hit = f & es[27:23];
    pick = '0;
    if      (hit[4]) pick = 5'b10000;
    else if (hit[3]) pick = 5'b01000;
    else if (hit[2]) pick = 5'b00100;
    else if (hit[1]) pick = 5'b00010;
    else if (hit[0]) pick = 5'b00001;
    et = |hit;
    if (et) begin
      es[4:0] = pick;
      es[16:14] = 3'b001;
    end else begin
      es[4:0] = f;
      es[9:5] = es[9:5] | f;
      epc = enpc;
      enpc = enpc + 4;
    end
    @(negedge clk);
    op_valid = 1'b1; op_flags = f;
    @(posedge clk); #1;
    op_valid = 1'b0;
    check_all(req);
  endtask

  task automatic t_reset;
    es = '0; epc = '0; enpc = 4; et = 1'b0;
    check_all("R1");
  endtask

  task automatic t_no_trap;
    load(32'h0000_0000, 32'h100, 32'h104, 1'b0, 5'd0);
    op(5'b00101, "R4");
    op(5'b01010, "R4");
    op(5'b00000, "R8");
    op(5'b10000, "R7");
  endtask

  task automatic t_trap_single;
    load(32'h0080_0000, 32'h200, 32'h204, 1'b0, 5'd0);
    op(5'b00110, "R4");
    op(5'b00001, "R3");
    op(5'b00011, "R6");
    op(5'b00000, "R8");
  endtask

  task automatic t_trap_priority;
    load(32'h0F80_0000, 32'h300, 32'h304, 1'b0, 5'd0);
    op(5'b11111, "R5");
    op(5'b01110, "R5");
    op(5'b00111, "R5");
    op(5'b00011, "R5");
    load(32'h0300_0000, 32'h400, 32'h404, 1'b0, 5'd0);
    op(5'b11110, "R5");
    op(5'b10100, "R7");
  endtask

  task automatic t_preserve;
    load(32'hF07A_0000 | 32'h0200_0000 | 32'h0000_3C00, 32'h500, 32'h504, 1'b0, 5'd0);
    op(5'b00001, "R9");
    op(5'b01001, "R9");
  endtask

  task automatic t_idle;
    repeat (3) @(negedge clk);
    #3;
    et = 1'b0;
    check_all("R9");
  endtask

  task automatic t_load_priority;
    load(32'h0080_0000, 32'h600, 32'h604, 1'b1, 5'b11111);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    #9;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_no_trap();
    t_trap_single();
    t_trap_priority();
    t_preserve();
    t_idle();
    t_load_priority();
    t_idle();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule